// File: doc/BRIEF.md
# Early-Evaluation Two-Way Join with Anti-Token Cancellation

This block is the control and steering for a multiplexer node in an elastic (latency-insensitive) datapath. A typical use is a next-address choice between a sequential address and a jump target. A conventional join waits for every input. This join completes as soon as two tokens are present: the select token and the data token the select value points at. The input that was not chosen is never waited for.

An unchosen input may hold no token when the join fires. For each such input the join records that it owes that input one negative token (an anti-token). The debt is paid off in one of two ways. The next positive token that reaches the input is swallowed and never forwarded. Otherwise the anti-token is offered upstream on a backward valid/stop pair and removed when the producer accepts it. If the unchosen input already holds a token at the firing, that token is consumed on the spot and no debt is recorded.

Each data input has four control wires: a forward valid and a backward stop for positive tokens, and a backward valid and a forward stop for anti-tokens. The select input and the output have only the forward pair. Each input keeps a saturating count of the anti-tokens it owes. While the count of an unchosen input is full, the join holds its output back.

Top module: `evj_mux_join`

## Requirements
- R1: After reset every owed-anti-token count is zero: `out_vp` is 0, `in_vn` is all zeros and `sel_sp` is 1 while no input is presented.
- R2: With `sel_vp`=1, select value s (s=0 chooses the low DW bits of `in_data`, s=1 the next DW bits), a usable token on input s and `out_sp`=0, the join fires in that cycle. `out_vp`=1, `out_data` equals the data of input s, and `sel_sp`=0 and `in_sp[s]`=0 in the same cycle.
- R3: The join fires without a token on the unchosen input.
- R4: If the unchosen input has no token at a firing, that input owes one anti-token. The next positive token on it is taken (`in_sp`=0) and dropped, and it is never seen at the output.
- R5: If the unchosen input holds a token at a firing, that token is taken in the same cycle, and no anti-token is owed.
- R6: An input that owes anti-tokens and has no positive token present drives `in_vn`=1. With `in_sn`=0 one anti-token leaves upstream at the clock edge. With `in_sn`=1 it stays owed.
- R7: While `out_sp`=1, nothing is consumed (`sel_sp`=1 and `in_sp[s]`=1), and `out_vp` and `out_data` stay unchanged into the next cycle.
- R8: Each input owes at most ANTI_MAX anti-tokens. While the unchosen input owes ANTI_MAX, `out_vp` is 0. The join resumes once that count drops.
- R9: An input that owes anti-tokens is not usable as the chosen input. A token arriving on it is cancelled and the output waits.
- R10: Over any timing of the three producers and the consumer, the output token stream equals element-wise selection between the two data streams by the select stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| sel_vp | input | 1 | Select token present |
| sel_val | input | SEL_W | Select value, the index of the input to forward |
| sel_sp | output | 1 | Stop for the select token (0 = taken this cycle) |
| in_vp | input | NUM_IN | Positive token present, one bit per data input |
| in_data | input | NUM_IN*DW | Data of each input, input i in bits i*DW upward |
| in_sp | output | NUM_IN | Stop for positive tokens (0 = taken this cycle) |
| in_vn | output | NUM_IN | Anti-token offered upstream on each input |
| in_sn | input | NUM_IN | Upstream refuses the offered anti-token |
| out_vp | output | 1 | Output token present |
| out_data | output | DW | Output data |
| out_sp | input | 1 | Downstream stop for the output token |

## Verification
The bench goes after the moment a debt is created and the moment it is paid. If a design forwarded a late token on an unchosen input instead of dropping it, the output stream would drift by one element. If it recorded a debt when the unchosen token was already present, it would later swallow a good token. Saturation is driven by holding the anti-token stop high until the count is full. A design that wrapped the count would lose debts, and a design that ignored the full count would fire past it. A long random run with independent producer gaps, random anti-token acceptance and random output stalls compares every output token with the element-wise reference selection. At the end it checks that both data producers have been fully drained.

// File: rtl/evj_pkg.sv
package evj_pkg;
  // Per-cycle order from the firing logic to one input slot.
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,  // no firing this cycle
    CMD_USE  = 2'd1,  // this input is the chosen one: take its token
    CMD_SKIP = 2'd2   // this input is not chosen: take its token or owe one
  } slot_cmd_e;
endpackage

// File: rtl/evj_antitoken_slot.sv
module evj_antitoken_slot
  import evj_pkg::*;
#(
  parameter int ANTI_MAX = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tok_vp,
  output logic      tok_sp,
  output logic      anti_vn,
  input  logic      anti_sn,
  input  slot_cmd_e cmd,
  output logic      tok_ready,
  output logic      skip_ok
);
  localparam int CNT_W = $clog2(ANTI_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ANTI_MAX);

  logic [CNT_W-1:0] owed_q, owed_d;
  logic             owed_en;
  logic             pend, annul, leave, owe, pay;

  assign pend      = (owed_q != '0);
  assign annul     = pend & tok_vp;            // positive meets negative here
  assign leave     = pend & ~tok_vp & ~anti_sn; // anti-token accepted upstream
  assign pay       = annul | leave;
  assign tok_ready = tok_vp & ~pend;
  assign owe       = (cmd == CMD_SKIP) & ~tok_ready;
  assign skip_ok   = (owed_q != CNT_TOP);
  assign anti_vn   = pend & ~tok_vp;
  assign tok_sp    = ~(annul | (cmd == CMD_USE) | ((cmd == CMD_SKIP) & tok_ready));

  always_comb begin
    owed_en = owe | pay;
    owed_d  = owed_q;
    if (owe && !pay)
      owed_d = owed_q + 1'b1;
    else if (!owe && pay)
      owed_d = owed_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      owed_q <= '0;
    else if (owed_en)
      owed_q <= owed_d;
  end

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= CNT_TOP); // R8
  AST_SKIP_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SKIP) |-> (owed_q != CNT_TOP)); // R8
  AST_ANNUL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && tok_vp && cmd != CMD_SKIP) |=> (owed_q == $past(owed_q) - 1'b1)); // R4
  AST_OWE_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SKIP && !tok_vp && (owed_q == '0 || anti_sn)) |=>
      (owed_q == $past(owed_q) + 1'b1)); // R4
  AST_USE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_USE) |-> (tok_ready && !tok_sp)); // R9
endmodule

// File: rtl/evj_fire_ctrl.sv
module evj_fire_ctrl
  import evj_pkg::*;
#(
  parameter int NUM_IN = 2,
  parameter int SEL_W  = 1
) (
  input  logic              sel_vp,
  input  logic [SEL_W-1:0]  sel_val,
  input  logic [NUM_IN-1:0] tok_ready,
  input  logic [NUM_IN-1:0] skip_ok,
  input  logic              out_sp,
  output logic              go,
  output logic              fire,
  output slot_cmd_e         cmd [NUM_IN]
);
  logic rest_ok;

  always_comb begin
    rest_ok = 1'b1;
    for (int i = 0; i < NUM_IN; i++) begin
      if (SEL_W'(i) != sel_val)
        rest_ok = rest_ok & skip_ok[i];
    end
    go   = sel_vp & tok_ready[sel_val] & rest_ok;
    fire = go & ~out_sp;
    for (int i = 0; i < NUM_IN; i++) begin
      if (!fire)
        cmd[i] = CMD_NONE;
      else if (SEL_W'(i) == sel_val)
        cmd[i] = CMD_USE;
      else
        cmd[i] = CMD_SKIP;
    end
  end
endmodule

// File: rtl/evj_mux_join.sv
module evj_mux_join
  import evj_pkg::*;
#(
  parameter int NUM_IN   = 2,  // power of two, at least 2
  parameter int DW       = 16,
  parameter int ANTI_MAX = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_vp,
  input  logic [$clog2(NUM_IN)-1:0]  sel_val,
  output logic                       sel_sp,
  input  logic [NUM_IN-1:0]          in_vp,
  input  logic [NUM_IN*DW-1:0]       in_data,
  output logic [NUM_IN-1:0]          in_sp,
  output logic [NUM_IN-1:0]          in_vn,
  input  logic [NUM_IN-1:0]          in_sn,
  output logic                       out_vp,
  output logic [DW-1:0]              out_data,
  input  logic                       out_sp
);
  localparam int SEL_W = $clog2(NUM_IN);

  logic [NUM_IN-1:0] tok_ready, skip_ok;
  logic              go, fire;
  slot_cmd_e         cmd [NUM_IN];

  evj_fire_ctrl #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_fire (
    .sel_vp   (sel_vp),
    .sel_val  (sel_val),
    .tok_ready(tok_ready),
    .skip_ok  (skip_ok),
    .out_sp   (out_sp),
    .go       (go),
    .fire     (fire),
    .cmd      (cmd)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_slot
    evj_antitoken_slot #(.ANTI_MAX(ANTI_MAX)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tok_vp   (in_vp[g]),
      .tok_sp   (in_sp[g]),
      .anti_vn  (in_vn[g]),
      .anti_sn  (in_sn[g]),
      .cmd      (cmd[g]),
      .tok_ready(tok_ready[g]),
      .skip_ok  (skip_ok[g])
    );
  end

  assign out_vp   = go;
  assign sel_sp   = ~fire;
  assign out_data = in_data[int'(sel_val)*DW +: DW];

  AST_SEL_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vp && !sel_sp) |-> (out_vp && !out_sp && !in_sp[sel_val])); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vp && out_sp) |=> (out_vp && $stable(out_data))); // R7
  AST_ANTI_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_vn & in_vp) == '0)); // R6
endmodule

// File: tb/evj_mux_join_bench.sv
module evj_mux_join_bench;
  localparam int NI = 2;
  localparam int DW = 16;
  localparam int AM = 3;
  localparam int L  = 400;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_vp, sel_sp, out_vp, out_sp;
  logic [0:0]    sel_val;
  logic [NI-1:0] in_vp, in_sp, in_vn, in_sn;
  logic [NI*DW-1:0] in_data;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  evj_mux_join #(.NUM_IN(NI), .DW(DW), .ANTI_MAX(AM)) u_evj_mux_join (
    .clk(clk), .rst_n(rst_n),
    .sel_vp(sel_vp), .sel_val(sel_val), .sel_sp(sel_sp),
    .in_vp(in_vp), .in_data(in_data), .in_sp(in_sp),
    .in_vn(in_vn), .in_sn(in_sn),
    .out_vp(out_vp), .out_data(out_data), .out_sp(out_sp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_pick(input bit s, input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    return s ? b : a;
  endfunction

  task automatic drive(input bit sv, input bit s, input logic [1:0] vp,
                       input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [1:0] sn, input bit osp);
    @(negedge clk);
    sel_vp = sv; sel_val = s; in_vp = vp; in_data = {b, a};
    in_sn = sn; out_sp = osp;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sel_vp = 0; sel_val = 0; in_vp = 0; in_data = '0; in_sn = 2'b11; out_sp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  logic [DW-1:0] da [L];
  logic [DW-1:0] db [L];
  bit            ss [L];

  initial begin
    int ia, ib, isx, io, cyc;
    bit oa, ob, os;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    sel_vp = 0; sel_val = 0; in_vp = 0; in_data = '0; in_sn = 2'b11; out_sp = 0;
    do_reset();
    #1;
    // reset state
    chk(out_vp == 0, "R1", "out_vp after reset", out_vp, 0);
    chk(in_vn == 0, "R1", "in_vn after reset", in_vn, 0);
    chk(sel_sp == 1, "R1", "sel_sp after reset", sel_sp, 1);

    // choose input 1 while input 0 is empty
    drive(1, 1, 2'b10, 16'h0, 16'hB001, 2'b11, 0);
    chk(out_vp == 1, "R3", "fires without unchosen token", out_vp, 1);
    chk(out_data == 16'hB001, "R2", "out_data", out_data, 16'hB001);
    chk(sel_sp == 0 && in_sp[1] == 0, "R2", "sel/chosen taken", {sel_sp, in_sp[1]}, 0);
    drive(0, 0, 2'b00, 16'h0, 16'h0, 2'b11, 0);
    chk(in_vn[0] == 1, "R6", "anti-token offered", in_vn[0], 1);
    chk(out_vp == 0, "R6", "no output without select", out_vp, 0);
    drive(0, 0, 2'b01, 16'hA000, 16'h0, 2'b11, 0);
    chk(in_sp[0] == 0, "R4", "late token swallowed", in_sp[0], 0);
    chk(in_vn[0] == 0, "R6", "no offer with token present", in_vn[0], 0);
    drive(0, 0, 2'b01, 16'hA000, 16'h0, 2'b11, 0);
    chk(in_sp[0] == 1, "R4", "only one token swallowed", in_sp[0], 1);

    // both present
    drive(1, 0, 2'b11, 16'hA002, 16'hB002, 2'b11, 0);
    chk(out_data == 16'hA002 && out_vp, "R2", "out_data sel 0", out_data, 16'hA002);
    chk(in_sp == 2'b00, "R5", "unchosen present taken", in_sp, 0);
    drive(0, 0, 2'b00, 16'h0, 16'h0, 2'b11, 0);
    chk(in_vn == 2'b00, "R5", "no debt after present unchosen", in_vn, 0);

    // output stall
    drive(1, 1, 2'b10, 16'h0, 16'hB003, 2'b11, 1);
    chk(out_vp == 1 && sel_sp == 1 && in_sp[1] == 1, "R7", "stall takes nothing",
        {out_vp, sel_sp, in_sp[1]}, 3'b111);
    drive(1, 1, 2'b10, 16'h0, 16'hB003, 2'b11, 1);
    chk(out_data == 16'hB003 && out_vp, "R7", "held data", out_data, 16'hB003);
    chk(in_vn == 2'b00, "R7", "no debt while stalled", in_vn, 0);
    drive(1, 1, 2'b10, 16'h0, 16'hB003, 2'b11, 0);
    chk(in_sp[1] == 0, "R7", "taken after release", in_sp[1], 0);

    // saturate input 0 debt (now 1)
    drive(1, 1, 2'b10, 16'h0, 16'hB004, 2'b11, 0);
    chk(out_vp == 1, "R8", "fire at debt 1", out_vp, 1);
    drive(1, 1, 2'b10, 16'h0, 16'hB005, 2'b11, 0);
    chk(out_vp == 1, "R8", "fire at debt 2", out_vp, 1);
    drive(1, 1, 2'b10, 16'h0, 16'hB006, 2'b11, 0);
    chk(out_vp == 0 && sel_sp == 1, "R8", "stall at full debt", out_vp, 0);
    drive(1, 1, 2'b10, 16'h0, 16'hB006, 2'b10, 0);
    chk(out_vp == 0 && in_vn[0] == 1, "R8", "still full while paying", out_vp, 0);
    drive(1, 1, 2'b10, 16'h0, 16'hB006, 2'b11, 0);
    chk(out_vp == 1 && out_data == 16'hB006, "R8", "resume after payment", out_data, 16'hB006);

    // chosen input with debt (debt 3 again)
    drive(1, 0, 2'b01, 16'hA007, 16'h0, 2'b11, 0);
    chk(out_vp == 0, "R9", "indebted input not usable", out_vp, 0);
    chk(in_sp[0] == 0, "R9", "token on indebted input cancelled", in_sp[0], 0);

    // random stream phase
    do_reset();
    for (int k = 0; k < L; k++) begin
      da[k] = DW'($urandom); db[k] = DW'($urandom); ss[k] = 1'($urandom);
    end
    ia = 0; ib = 0; isx = 0; io = 0; oa = 0; ob = 0; os = 0; cyc = 0;
    while (!(io == L && ia == L && ib == L) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (!os && isx < L && ($urandom % 4) != 0) os = 1;
      if (!oa && ia < L && ($urandom % 3) != 0) oa = 1;
      if (!ob && ib < L && ($urandom % 3) != 0) ob = 1;
      sel_vp  = os;
      sel_val = os ? ss[isx] : 1'($urandom);
      in_vp   = {ob, oa};
      in_data = {ob ? db[ib] : DW'($urandom), oa ? da[ia] : DW'($urandom)};
      in_sn   = 2'($urandom);
      out_sp  = (($urandom % 4) == 0);
      #1;
      if (sel_vp && !sel_sp) begin isx++; os = 0; end
      if (oa && !in_sp[0]) begin ia++; oa = 0; end
      else if (!oa && in_vn[0] && !in_sn[0]) ia++;
      if (ob && !in_sp[1]) begin ib++; ob = 0; end
      else if (!ob && in_vn[1] && !in_sn[1]) ib++;
      if (out_vp && !out_sp) begin
        if (io < L)
          chk(out_data == ref_pick(ss[io], da[io], db[io]), "R10", "stream element",
              out_data, ref_pick(ss[io], da[io], db[io]));
        else
          chk(0, "R10", "extra output token", io, L);
        io++;
      end
    end
    chk(cyc < 20000, "R10", "watchdog", cyc, 20000);
    chk(io == L, "R10", "output count", io, L);
    chk(ia == L && ib == L, "R4", "producers drained", ia + ib, 2 * L);
    #1;
    chk(in_vn == 2'b00, "R6", "no debt left", in_vn, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule